// File: doc/BRIEF.md
# Register-Bank Serial Slave

This block lets an external I2C host read and write a bank of 256 eight-bit control registers. SCL and SDA are oversampled by the fast system clock. Each line passes through a synchronizer and a majority-free agreement filter before its edges are detected. The block recognises START and STOP, matches a fixed 7-bit device address, and acknowledges by pulling SDA low through an open-drain enable. The rest of the chip reads any register at any time through a combinational parallel port.

A write transfer is address byte, pointer byte, then any number of data bytes. Each data byte lands at the pointer, and the pointer then advances. A read transfer has no pointer byte of its own. Data begins at wherever the last write left the pointer, and the pointer advances after every byte sent. The pointer is eight bits wide and rolls over from 0xFF to 0x00.

Each SCL high and low phase must last at least 16 system clocks with the default filter settings. This leaves room for the 7-cycle detection latency. A repeated START restarts the address phase exactly like a fresh START.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset the SDA pull-down enable is off and every register reads 0x00 on the parallel port.
- R2: A first byte carrying device address 7'b1000000 in bits 7..1 is acknowledged. The slave holds SDA low throughout the high phase of the ninth clock.
- R3: A first byte with any other address is not acknowledged. SDA stays released for the rest of the transfer until the next START or STOP, and no register changes.
- R4: In a write (bit 0 of the first byte is 0), the second byte loads the pointer. Each later byte is stored at the pointer, after which the pointer increments. Stored values appear on the parallel read port.
- R5: The slave acknowledges the pointer byte and every data byte written.
- R6: In a read (bit 0 of the first byte is 1), the bytes returned come from the pointer left by the previous write. They are sent MSB first, and the pointer increments after each byte sent.
- R7: The pointer wraps from 0xFF to 0x00, both while writing and while reading.
- R8: When the master leaves SDA high in the acknowledge slot after a read byte, the slave sends nothing further and keeps SDA released until the next START or STOP.
- R9: A repeated START inside a transfer releases SDA and restarts address matching. A pointer set before it is used by a read after it.
- R10: A STOP releases SDA. A byte cut short by a STOP is discarded, and the next transfer works normally.
- R11: The slave only turns its SDA pull-down on while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_raddr_i | input | 8 | Register index for the parallel read port |
| reg_rdata_o | output | 8 | Register contents at reg_raddr_i, combinational |

## Verification
A bus edge reaches the detector six clocks after it appears at a pin: two synchronizer stages, three filter stages and one edge register. The SDA enable and any register write follow one clock later, so the slave reacts seven clocks after an SCL edge. The bench holds every SCL phase for 40 clocks and samples SDA 20 clocks into the high phase, well after the slave's drive has settled. Register contents are read on the parallel port one falling clock edge after the index is set, and only after the transfer's STOP.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK, ST_IGNORE
  } slv_state_e;

  typedef enum logic [1:0] {
    RB_ADDR, RB_PTR, RB_DATA
  } rx_role_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   level_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '1;
      hist_q  <= '1;
      level_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      // level moves only once the whole window agrees
      if (&hist_q)       level_q <= 1'b1;
      else if (~|hist_q) level_q <= 1'b0;
      prev_q <= level_q;
    end
  end

  assign level_o = level_q;
  assign rise_o  = level_q & ~prev_q;
  assign fall_o  = ~level_q & prev_q;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] bus_raddr_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [AW-1:0] par_raddr_i,
  output logic [DW-1:0] par_rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))   mem_q[g] <= wdata_i;
    end
  end

  assign bus_rdata_o = mem_q[bus_raddr_i];
  assign par_rdata_o = mem_q[par_raddr_i];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [REG_DW-1:0] rd_data_i,
  output logic [REG_AW-1:0] ptr_o,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] wr_addr_o,
  output logic [REG_DW-1:0] wr_data_o,
  output logic              sda_oe_o
);
  localparam int unsigned CNT_W = $clog2(REG_DW);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(REG_DW - 1);

  slv_state_e        state_q;
  rx_role_e          role_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [REG_DW-1:0] rx_q, tx_q;
  logic [REG_AW-1:0] ptr_q;
  logic              byte_done_q, go_tx_q, mack_q, oe_q;

  assign wr_en_o   = (state_q == ST_RX) && scl_fall_i && byte_done_q &&
                     (role_q == RB_DATA) && !start_i && !stop_i;
  assign wr_addr_o = ptr_q;
  assign wr_data_o = rx_q;
  assign ptr_o     = ptr_q;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      role_q      <= RB_ADDR;
      cnt_q       <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      ptr_q       <= '0;
      byte_done_q <= 1'b0;
      go_tx_q     <= 1'b0;
      mack_q      <= 1'b0;
      oe_q        <= 1'b0;
    end else if (start_i) begin
      state_q     <= ST_RX;
      role_q      <= RB_ADDR;
      cnt_q       <= '0;
      byte_done_q <= 1'b0;
      oe_q        <= 1'b0;
    end else if (stop_i) begin
      state_q     <= ST_IDLE;
      byte_done_q <= 1'b0;
      oe_q        <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise_i) begin
            rx_q <= {rx_q[REG_DW-2:0], sda_i};
            if (cnt_q == LAST_BIT) begin
              byte_done_q <= 1'b1;
              cnt_q       <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          if (scl_fall_i && byte_done_q) begin
            byte_done_q <= 1'b0;
            unique case (role_q)
              RB_ADDR: begin
                if (rx_q[REG_DW-1:1] == DEV_ADDR) begin
                  oe_q    <= 1'b1;
                  go_tx_q <= rx_q[0];
                  role_q  <= RB_PTR;
                  state_q <= ST_ACK;
                end else begin
                  state_q <= ST_IGNORE;
                end
              end
              RB_PTR: begin
                ptr_q   <= rx_q;
                oe_q    <= 1'b1;
                go_tx_q <= 1'b0;
                role_q  <= RB_DATA;
                state_q <= ST_ACK;
              end
              default: begin
                ptr_q   <= ptr_q + 1'b1;
                oe_q    <= 1'b1;
                go_tx_q <= 1'b0;
                state_q <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            if (go_tx_q) begin
              tx_q    <= rd_data_i;
              oe_q    <= ~rd_data_i[REG_DW-1];
              state_q <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == LAST_BIT) begin
              oe_q    <= 1'b0;
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_RACK;
            end else begin
              tx_q  <= {tx_q[REG_DW-2:0], 1'b0};
              oe_q  <= ~tx_q[REG_DW-2];
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) mack_q <= ~sda_i;
          if (scl_fall_i) begin
            if (mack_q) begin
              tx_q    <= rd_data_i;
              oe_q    <= ~rd_data_i[REG_DW-1];
              cnt_q   <= '0;
              state_q <= ST_TX;
            end else begin
              state_q <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'b1000000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [REG_AW-1:0] reg_raddr_i,
  output logic [REG_DW-1:0] reg_rdata_o
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw, lvl, rise, fall;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) i_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[g]),
      .level_o(lvl[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  assign scl_lvl   = lvl[0];
  assign sda_lvl   = lvl[1];
  assign scl_rise  = rise[0];
  assign scl_fall  = fall[0];
  assign start_det = fall[1] & scl_lvl;
  assign stop_det  = rise[1] & scl_lvl;

  logic              wr_en;
  logic [REG_AW-1:0] wr_addr, ptr;
  logic [REG_DW-1:0] wr_data, bus_rdata;

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_i     (sda_lvl),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .rd_data_i (bus_rdata),
    .ptr_o     (ptr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .sda_oe_o  (sda_oe_o)
  );

  i2c_reg_bank #(.AW(REG_AW), .DW(REG_DW)) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (wr_en),
    .waddr_i    (wr_addr),
    .wdata_i    (wr_data),
    .bus_raddr_i(ptr),
    .bus_rdata_o(bus_rdata),
    .par_raddr_i(reg_raddr_i),
    .par_rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_oe_o,
  input logic       scl_lvl,
  input logic       start_det,
  input logic       stop_det,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] ptr
);
  a_r11_pull_only_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_lvl);

  a_r9_start_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);

  a_r10_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> ptr == 8'($past(wr_addr) + 8'd1));

  a_r5_ack_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> sda_oe_o);

  a_r4_store_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !scl_lvl);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sda_oe_o (sda_oe_o),
  .scl_lvl  (scl_lvl),
  .start_det(start_det),
  .stop_det (stop_det),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .ptr      (ptr)
);

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  localparam int HALF = 40;
  localparam int QTR  = HALF / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe;
  logic       sda_bus;
  logic [7:0] raddr = 8'h00;
  logic [7:0] rdata;
  int         n_chk = 0, n_err = 0;
  int         oe_viol = 0;
  logic       oe_prev = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_reg_slave i_i2c_reg_slave (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_oe_o   (sda_oe),
    .reg_raddr_i(raddr),
    .reg_rdata_o(rdata)
  );

  // R11 monitor: pull-down may only switch on while SCL is low
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl_m) oe_viol++;
    oe_prev <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(QTR);
    scl_m = 1'b1; wt(HALF);
    sda_m = 1'b0; wt(HALF);
    scl_m = 1'b0; wt(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(QTR);
    scl_m = 1'b1; wt(HALF);
    sda_m = 1'b1; wt(HALF);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(QTR);
    scl_m = 1'b1; wt(HALF);
    scl_m = 1'b0; wt(QTR);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wt(QTR);
    scl_m = 1'b1; wt(QTR);
    b = sda_bus; wt(QTR);
    scl_m = 1'b0; wt(QTR);
  endtask

  task automatic write_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    logic b;
    for (int i = 0; i < 8; i++) begin
      recv_bit(b);
      d = {d[6:0], b};
    end
    send_bit(~mack);
  endtask

  task automatic reg_is(input logic [7:0] a, input logic [7:0] exp, input string req);
    raddr = a; wt(1);
    check(rdata == exp, req, rdata, exp);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic ak;
    bus_start();
    write_byte(8'h80, ak); check(ak, "R2", ak, 1);
    write_byte(p, ak);     check(ak, "R5", ak, 1);
    bus_stop();
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1", sda_oe, 0);
    reg_is(8'h00, 8'h00, "R1");
    reg_is(8'h10, 8'h00, "R1");
    reg_is(8'hFF, 8'h00, "R1");
  endtask

  task automatic t_write_burst();
    logic ak;
    logic [7:0] vals [3] = '{8'hA5, 8'h3C, 8'h7E};
    bus_start();
    write_byte(8'h80, ak); check(ak, "R2", ak, 1);
    write_byte(8'h10, ak); check(ak, "R5", ak, 1);
    foreach (vals[i]) begin
      write_byte(vals[i], ak); check(ak, "R5", ak, 1);
    end
    bus_stop();
    foreach (vals[i]) reg_is(8'(8'h10 + i), vals[i], "R4");
    reg_is(8'h13, 8'h00, "R4");
  endtask

  task automatic t_read_burst();
    logic ak;
    logic [7:0] d;
    set_ptr(8'h10);
    bus_start();
    write_byte(8'h81, ak); check(ak, "R2", ak, 1);
    read_byte(1'b1, d); check(d == 8'hA5, "R6", d, 8'hA5);
    read_byte(1'b1, d); check(d == 8'h3C, "R6", d, 8'h3C);
    read_byte(1'b0, d); check(d == 8'h7E, "R6", d, 8'h7E);
    // after NACK the slave must stay silent (reg 0x13 holds 0x00)
    read_byte(1'b0, d); check(d == 8'hFF, "R8", d, 8'hFF);
    check(sda_oe == 1'b0, "R8", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic ak;
    logic [7:0] d;
    bus_start();
    write_byte(8'h80, ak); check(ak, "R2", ak, 1);
    write_byte(8'hFE, ak); check(ak, "R5", ak, 1);
    write_byte(8'h11, ak); check(ak, "R5", ak, 1);
    write_byte(8'h22, ak); check(ak, "R5", ak, 1);
    write_byte(8'h33, ak); check(ak, "R5", ak, 1);
    bus_stop();
    reg_is(8'hFE, 8'h11, "R7");
    reg_is(8'hFF, 8'h22, "R7");
    reg_is(8'h00, 8'h33, "R7");
    set_ptr(8'hFF);
    bus_start();
    write_byte(8'h81, ak); check(ak, "R2", ak, 1);
    read_byte(1'b1, d); check(d == 8'h22, "R7", d, 8'h22);
    read_byte(1'b0, d); check(d == 8'h33, "R7", d, 8'h33);
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic ak;
    bus_start();
    write_byte(8'h42, ak); check(!ak, "R3", ak, 0);
    write_byte(8'h20, ak); check(!ak, "R3", ak, 0);
    write_byte(8'h99, ak); check(!ak, "R3", ak, 0);
    bus_stop();
    reg_is(8'h20, 8'h00, "R3");
    bus_start();
    write_byte(8'h00, ak); check(!ak, "R3", ak, 0);
    bus_stop();
  endtask

  task automatic t_rep_start();
    logic ak;
    logic [7:0] d;
    bus_start();
    write_byte(8'h80, ak); check(ak, "R2", ak, 1);
    write_byte(8'h11, ak); check(ak, "R5", ak, 1);
    bus_start();
    check(sda_oe == 1'b0, "R9", sda_oe, 0);
    write_byte(8'h81, ak); check(ak, "R9", ak, 1);
    read_byte(1'b0, d); check(d == 8'h3C, "R9", d, 8'h3C);
    bus_stop();
  endtask

  task automatic t_abort();
    logic ak;
    bus_start();
    write_byte(8'h80, ak); check(ak, "R2", ak, 1);
    write_byte(8'h40, ak); check(ak, "R5", ak, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    check(sda_oe == 1'b0, "R10", sda_oe, 0);
    reg_is(8'h40, 8'h00, "R10");
    bus_start();
    write_byte(8'h80, ak); check(ak, "R10", ak, 1);
    write_byte(8'h40, ak); check(ak, "R10", ak, 1);
    write_byte(8'h5A, ak); check(ak, "R10", ak, 1);
    bus_stop();
    reg_is(8'h40, 8'h5A, "R10");
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(10);
    t_reset();
    t_write_burst();
    t_read_burst();
    t_wrap();
    t_mismatch();
    t_rep_start();
    t_abort();
    check(oe_viol == 0, "R11", oe_viol, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule